// File: doc/BRIEF.md
# Shared Multiply and Shift Unit

This block is one multiplier that a pair of processor cores share for their occasional multiply and shift work. Each core raises a request carrying a 3-bit operation code and two 64-bit operands. A round-robin arbiter accepts at most one request per cycle and grants it in the same cycle. The losing core holds its request until it is granted.

Every accepted operation passes through a three-stage pipeline:
- operand preparation,
- a signed 66 × 66 multiply,
- selection of the low or high half of the product.

The result comes back with a valid pulse addressed to the core that issued it. Shifts have no barrel shifter. A left shift by n multiplies the operand by 2^n and keeps the low half. A right shift by n multiplies by 2^(64−n) and keeps the high half; a zero amount maps naturally onto 2^64. The arithmetic right shift extends the operand with its sign bit and uses the same path.

Operation codes: 0 multiply-low, 1 signed×signed high, 2 signed×unsigned high, 3 unsigned×unsigned high, 4 shift left logical, 5 shift right logical, 6 shift right arithmetic, 7 unused.

Top module: `mulshift_unit`

## Requirements
- R1: Code 0 returns the low 64 bits of reqA × reqB. This is the same for signed and unsigned operands.
- R2: Code 1 returns bits 127:64 of the product with both operands taken as two's-complement signed.
- R3: Code 2 returns bits 127:64 of the product with reqA signed and reqB unsigned.
- R4: Code 3 returns bits 127:64 of the product with both operands unsigned.
- R5: Code 4 returns reqA shifted left by reqB[5:0] with zero fill. Bits 63:6 of reqB have no effect.
- R6: Code 5 returns reqA shifted right by reqB[5:0] with zero fill. An amount of 0 returns reqA unchanged.
- R7: Code 6 returns reqA shifted right by reqB[5:0], filling with reqA[63]. An amount of 0 returns reqA, and bits 63:6 of reqB have no effect.
- R8: Code 7 returns a result of zero.
- R9: A request granted in cycle t yields rspValid one-hot for the requesting core in cycle t+3, with rspData holding its result. rspValid is low in t+1 and t+2 unless another request was granted earlier.
- R10: reqGrant is one-hot or zero and goes only to a requesting core. A lone requester is granted in the same cycle.
- R11: When both cores request, the grant alternates between them on consecutive cycles. The first tie after reset goes to core 0.
- R12: Reset clears the pipeline and the arbiter. No rspValid is raised during reset, nor afterwards for work accepted before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | NUM_CORES | Request from each core |
| reqOp | input | NUM_CORES×3 | Operation code per core |
| reqA | input | NUM_CORES×XLEN | First operand per core |
| reqB | input | NUM_CORES×XLEN | Second operand or shift amount per core |
| reqGrant | output | NUM_CORES | One-hot acceptance this cycle |
| rspValid | output | NUM_CORES | One-hot result pulse for the owning core |
| rspData | output | XLEN | Result of the operation in the last stage |

## Verification
The hardest state to reach is sustained contention: both cores requesting every cycle while earlier results are still in the pipe. Only there do the alternating grant and the per-core result routing interact. The stimulus resets first so the tie pointer is known, then holds both requests for four cycles with different operations. It then checks the grant pattern and each routed result as it leaves the pipeline.

A second hard case is a reset arriving with work in flight. The bench asserts reset one cycle after an acceptance and watches for a stray result pulse.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_SLL    = 3'd4,
    OP_SRL    = 3'd5,
    OP_SRA    = 3'd6,
    OP_NONE   = 3'd7
  } msOp_e;

  // stage-load strobes from control to datapath
  typedef struct packed {
    logic ld1;  // operand stage captures the granted request
    logic ld2;  // product stage captures the multiply
    logic ld3;  // result stage picks the product half
  } msStrobe_t;

endpackage

// File: rtl/mulshift_ctrl.sv
module mulshift_ctrl
  import mulshift_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int IDW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CORES-1:0] reqValid,
  output logic [NUM_CORES-1:0] reqGrant,
  output msStrobe_t            strobe,
  output logic [NUM_CORES-1:0] rspValid
);

  logic [IDW-1:0] ptr;
  logic [IDW-1:0] winner;
  logic [IDW-1:0] cand;
  logic           found;
  int             sum;

  // rotating-priority pick starting at ptr
  always_comb begin
    reqGrant = '0;
    winner   = '0;
    found    = 1'b0;
    sum      = 0;
    cand     = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      sum = int'(ptr) + i;
      if (sum >= NUM_CORES) sum = sum - NUM_CORES;
      cand = IDW'(sum);
      if (!found && reqValid[cand]) begin
        reqGrant[cand] = 1'b1;
        winner         = cand;
        found          = 1'b1;
      end
    end
  end

  logic           v1, v2, v3;
  logic [IDW-1:0] own1, own2, own3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr  <= '0;
      v1   <= 1'b0;
      v2   <= 1'b0;
      v3   <= 1'b0;
      own1 <= '0;
      own2 <= '0;
      own3 <= '0;
    end else begin
      if (found) begin
        ptr <= (winner == IDW'(NUM_CORES - 1)) ? '0 : winner + 1'b1;
      end
      v1   <= found;
      v2   <= v1;
      v3   <= v2;
      own1 <= winner;
      own2 <= own1;
      own3 <= own2;
    end
  end

  assign strobe.ld1 = found;
  assign strobe.ld2 = v1;
  assign strobe.ld3 = v2;

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_rsp
      assign rspValid[g] = v3 && (own3 == IDW'(g));
    end
  endgenerate

endmodule

// File: rtl/mulshift_dp.sv
module mulshift_dp
  import mulshift_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NUM_CORES = 2
) (
  input  logic                            clk,
  input  msStrobe_t                       strobe,
  input  logic [NUM_CORES-1:0]            selOneHot,
  input  logic [NUM_CORES-1:0][2:0]       reqOp,
  input  logic [NUM_CORES-1:0][XLEN-1:0]  reqA,
  input  logic [NUM_CORES-1:0][XLEN-1:0]  reqB,
  output logic [XLEN-1:0]                 result
);

  localparam int SHW   = $clog2(XLEN);
  localparam int EXT   = XLEN + 2;   // room for 2^XLEN as a positive signed value
  localparam int PRODW = 2 * XLEN;

  logic [XLEN-1:0] selA, selB;
  logic [2:0]      selOpRaw;
  msOp_e           selOp;

  // AND-OR operand mux driven by the one-hot grant
  always_comb begin
    selA     = '0;
    selB     = '0;
    selOpRaw = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (selOneHot[i]) begin
        selA     = selA | reqA[i];
        selB     = selB | reqB[i];
        selOpRaw = selOpRaw | reqOp[i];
      end
    end
    selOp = msOp_e'(selOpRaw);
  end

  logic [SHW-1:0]  shAmt;
  logic [SHW:0]    rightK;
  logic [EXT-1:0]  powLeft, powRight;
  logic [EXT-1:0]  sxA, zxA, sxB, zxB;
  logic [EXT-1:0]  prepA, prepB;

  assign shAmt    = selB[SHW-1:0];
  assign rightK   = (SHW+1)'(XLEN) - {1'b0, shAmt};
  assign powLeft  = EXT'(1) << shAmt;
  assign powRight = EXT'(1) << rightK;
  assign sxA      = {{2{selA[XLEN-1]}}, selA};
  assign zxA      = {2'b00, selA};
  assign sxB      = {{2{selB[XLEN-1]}}, selB};
  assign zxB      = {2'b00, selB};

  always_comb begin
    unique case (selOp)
      OP_MUL, OP_MULH: begin prepA = sxA; prepB = sxB;      end
      OP_MULHSU:       begin prepA = sxA; prepB = zxB;      end
      OP_MULHU:        begin prepA = zxA; prepB = zxB;      end
      OP_SLL:          begin prepA = zxA; prepB = powLeft;  end
      OP_SRL:          begin prepA = zxA; prepB = powRight; end
      OP_SRA:          begin prepA = sxA; prepB = powRight; end
      default:         begin prepA = '0;  prepB = '0;       end
    endcase
  end

  logic signed [EXT-1:0]   opA1, opB1;
  msOp_e                   op1, op2;
  logic        [PRODW-1:0] prod2;
  logic                    takeLow;

  assign takeLow = (op2 == OP_MUL) || (op2 == OP_SLL);

  always_ff @(posedge clk) begin
    if (strobe.ld1) begin
      opA1 <= $signed(prepA);
      opB1 <= $signed(prepB);
      op1  <= selOp;
    end
    if (strobe.ld2) begin
      prod2 <= PRODW'(opA1) * PRODW'(opB1);
      op2   <= op1;
    end
    if (strobe.ld3) begin
      result <= takeLow ? prod2[XLEN-1:0] : prod2[PRODW-1:XLEN];
    end
  end

endmodule

// File: rtl/mulshift_unit.sv
module mulshift_unit
  import mulshift_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NUM_CORES = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CORES-1:0]            reqValid,
  input  logic [NUM_CORES-1:0][2:0]       reqOp,
  input  logic [NUM_CORES-1:0][XLEN-1:0]  reqA,
  input  logic [NUM_CORES-1:0][XLEN-1:0]  reqB,
  output logic [NUM_CORES-1:0]            reqGrant,
  output logic [NUM_CORES-1:0]            rspValid,
  output logic [XLEN-1:0]                 rspData
);

  msStrobe_t strobe;

  mulshift_ctrl #(.NUM_CORES(NUM_CORES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqGrant (reqGrant),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  mulshift_dp #(.XLEN(XLEN), .NUM_CORES(NUM_CORES)) i_dp (
    .clk       (clk),
    .strobe    (strobe),
    .selOneHot (reqGrant),
    .reqOp     (reqOp),
    .reqA      (reqA),
    .reqB      (reqB),
    .result    (rspData)
  );

endmodule

// File: rtl/mulshift_chk.sv
module mulshift_chk #(
  parameter int NUM_CORES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] reqValid,
  input logic [NUM_CORES-1:0] reqGrant,
  input logic [NUM_CORES-1:0] rspValid
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant));

  p_grant_requested_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  p_lone_granted_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(reqValid) |-> (reqGrant == reqValid));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (rspValid == $past(reqGrant, 3)));

  p_rsp_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspValid));

  p_tie_alternates_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceRst != 2'd0) && (&reqValid) && $past(&reqValid)) |-> (reqGrant != $past(reqGrant)));

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rstN |=> (rspValid == '0));

endmodule

bind mulshift_unit mulshift_chk #(.NUM_CORES(NUM_CORES)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqGrant (reqGrant),
  .rspValid (rspValid)
);

// File: tb/test_mulshift_unit.sv
`timescale 1ns/1ps
module test_mulshift_unit;

  localparam real CLK_P = 5.0;
  localparam int  NV    = 21;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       reqValid = '0;
  logic [1:0][2:0]  reqOp = '0;
  logic [1:0][63:0] reqA = '0;
  logic [1:0][63:0] reqB = '0;
  logic [1:0]       reqGrant;
  logic [1:0]       rspValid;
  logic [63:0]      rspData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_P / 2.0) clk = ~clk;

  mulshift_unit i_mulshift_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqA(reqA), .reqB(reqB), .reqGrant(reqGrant),
    .rspValid(rspValid), .rspData(rspData)
  );

  // {port, op, a, b}
  localparam logic [131:0] VEC [NV] = '{
    {1'b0, 3'd0, 64'h0000_0000_1234_5678, 64'h0000_0000_0000_1000},
    {1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0007},
    {1'b0, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 3'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b0, 3'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000},
    {1'b1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 3'd2, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002},
    {1'b1, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 3'd3, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000},
    {1'b1, 3'd4, 64'h0123_4567_89AB_CDEF, 64'd4},
    {1'b0, 3'd4, 64'h0000_0000_0000_0001, 64'd63},
    {1'b1, 3'd4, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC4},
    {1'b0, 3'd4, 64'hDEAD_BEEF_0000_1111, 64'd0},
    {1'b0, 3'd5, 64'h8000_0000_0000_0001, 64'd1},
    {1'b1, 3'd5, 64'h8000_0000_0000_0001, 64'd0},
    {1'b0, 3'd5, 64'hF000_0000_0000_0000, 64'd63},
    {1'b1, 3'd6, 64'h8000_0000_0000_0000, 64'd4},
    {1'b0, 3'd6, 64'h8765_4321_0FED_CBA9, 64'd0},
    {1'b1, 3'd6, 64'h8000_0000_0000_0000, 64'd63},
    {1'b0, 3'd6, 64'h7000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF48},
    {1'b1, 3'd7, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_5678}
  };

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [127:0] sa = {{64{a[63]}}, a};
    logic [127:0] za = {64'b0, a};
    logic [127:0] sb = {{64{b[63]}}, b};
    logic [127:0] zb = {64'b0, b};
    logic [127:0] p;
    case (op)
      3'd0: begin p = sa * sb; return p[63:0];   end
      3'd1: begin p = sa * sb; return p[127:64]; end
      3'd2: begin p = sa * zb; return p[127:64]; end
      3'd3: begin p = za * zb; return p[127:64]; end
      3'd4: return a << b[5:0];
      3'd5: return a >> b[5:0];
      3'd6: return $signed(a) >>> b[5:0];
      default: return 64'd0;
    endcase
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runVec(input int p, input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] exp = model(op, a, b);
    logic [1:0]  hot = 2'b01 << p;
    @(negedge clk);
    reqValid    = hot;
    reqOp[p]    = op;
    reqA[p]     = a;
    reqB[p]     = b;
    #1;
    check(reqGrant == hot, "R10", 64'(reqGrant), 64'(hot));
    @(negedge clk);
    reqValid = '0;
    check(rspValid == 2'b00, "R9", 64'(rspValid), 64'd0);
    @(negedge clk);
    check(rspValid == 2'b00, "R9", 64'(rspValid), 64'd0);
    @(negedge clk);
    check(rspValid == hot, "R9", 64'(rspValid), 64'(hot));
    check(rspData == exp, opTag(op), rspData, exp);
  endtask

  task automatic flushAfterReset();
    // R12: accept one request, then reset while it is in flight
    @(negedge clk);
    reqValid = 2'b01; reqOp[0] = 3'd0; reqA[0] = 64'd5; reqB[0] = 64'd6;
    @(negedge clk);
    reqValid = '0;
    rstN = 1'b0;
    @(negedge clk);
    check(rspValid == 2'b00, "R12", 64'(rspValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rspValid == 2'b00, "R12", 64'(rspValid), 64'd0);
    end
  endtask

  task automatic contention();
    logic [63:0] a0 = 64'h0000_0000_0001_0003;
    logic [63:0] b0 = 64'h0000_0000_0000_0010;
    logic [63:0] a1 = 64'hC000_0000_0000_00F0;
    logic [63:0] b1 = 64'd4;
    logic [63:0] e0 = model(3'd0, a0, b0);
    logic [63:0] e1 = model(3'd6, a1, b1);
    logic [1:0]  expG;
    logic [1:0]  expV;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k < 4) begin
        reqValid = 2'b11;
        reqOp[0] = 3'd0; reqA[0] = a0; reqB[0] = b0;
        reqOp[1] = 3'd6; reqA[1] = a1; reqB[1] = b1;
      end else begin
        reqValid = 2'b00;
      end
      #1;
      if (k < 4) begin
        expG = (k % 2 == 0) ? 2'b01 : 2'b10;
        check(reqGrant == expG, "R11", 64'(reqGrant), 64'(expG));
      end
      if (k >= 3) begin
        expV = ((k - 3) % 2 == 0) ? 2'b01 : 2'b10;
        check(rspValid == expV, "R11", 64'(rspValid), 64'(expV));
        check(rspData == (expV[0] ? e0 : e1), "R9", rspData, expV[0] ? e0 : e1);
      end
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(rspValid == 2'b00, "R12", 64'(rspValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 2'b00, "R12", 64'(rspValid), 64'd0);
    for (int i = 0; i < NV; i++) begin
      runVec(int'(VEC[i][131]), VEC[i][130:128], VEC[i][127:64], VEC[i][63:0]);
    end
    flushAfterReset();
    contention();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule